// File: doc/BRIEF.md
# Load-or-Accumulate Register

This block keeps a running total in a single word register. Each accepted input word either starts a new total, or is added to the total already held. The `load` control bit selects which of the two happens. The datapath has three parts. A 2:1 operand selector feeds either zero or the stored total into one side of an adder. The input word goes into the other side. The adder's sum is written into the register on the rising clock edge.

Input words arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is always high. A beat is accepted on any rising edge where `in_valid` is high. On edges where `in_valid` is low, the register holds its value and `load` has no effect. The total is visible at all times on `acc_out`, which is the register's contents. It changes only at a rising edge. The sum wraps modulo 2^W and there is no carry or overflow output. A synchronous active-high reset clears the total.

Top module: `load_accum`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_out` becomes 0 after that edge, whatever the other inputs are.
- R2: When `in_valid` and `load` are both 1 at a rising edge (and `rst` is 0), `acc_out` becomes `in_data` after that edge.
- R3: When `in_valid` is 1 and `load` is 0 at a rising edge, `acc_out` becomes the previous `acc_out` plus `in_data` after that edge.
- R4: When `in_valid` is 0 at a rising edge, `acc_out` keeps its value, whatever `load` and `in_data` are.
- R5: `acc_out` changes only at a rising clock edge. Changes on the inputs between edges do not reach it.
- R6: The addition in R3 wraps modulo 2^W, with no carry kept. For example, with W=8, 200 + 100 gives 44.
- R7: `in_ready` is 1 in every cycle, including during reset, so the input stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the total |
| load | input | 1 | 1: restart the total with the input word; 0: add the input word to the total |
| in_valid | input | 1 | An input word is offered this cycle |
| in_ready | output | 1 | Always 1; the block accepts every offered word |
| in_data | input | W | Input word |
| acc_out | output | W | Current total held in the register |

## Verification
Assertions in the design check the register transfer on every clock edge:
- the reset clear;
- the load capture;
- the wrapped accumulate against the previous total;
- the hold on idle edges.

Some behaviours cannot be seen from a single edge, so only the bench's scenarios show them:
- that input changes between edges leave the output untouched;
- that a long run of accumulates and reloads matches the expected running sums, including the example sequence restarted at its fourth word;
- that a wrap really occurs at the word boundary.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [0:0] {
    ADD_BEHAV  = 1'b0,
    ADD_RIPPLE = 1'b1
  } adder_impl_e;

  function automatic logic full_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic full_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/acc_operand_mux.sv
module acc_operand_mux #(
  parameter int W = 8
) (
  input  logic         restart,
  input  logic [W-1:0] total,
  output logic [W-1:0] operand
);

  // Restart feeds zero so the adder passes the input word through unchanged.
  always_comb begin
    if (restart) operand = '0;
    else         operand = total;
  end

endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int                  W    = 8,
  parameter acc_pkg::adder_impl_e IMPL = acc_pkg::ADD_RIPPLE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  generate
    if (IMPL == acc_pkg::ADD_RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = acc_pkg::full_sum(a[i], b[i], carry[i]);
        // The carry out of the top bit is dropped: modulo 2^W.
        if (i < W - 1) begin : g_c
          assign carry[i+1] = acc_pkg::full_carry(a[i], b[i], carry[i]);
        end
      end
    end else begin : g_behav
      assign sum = a + b;
    end
  endgenerate

endmodule

// File: rtl/acc_word_reg.sv
module acc_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("R1: register not cleared after reset");

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q))
    else $error("R4: register changed without an accepted beat");

endmodule

// File: rtl/load_accum.sv
module load_accum #(
  parameter int                   W    = 8,
  parameter acc_pkg::adder_impl_e IMPL = acc_pkg::ADD_RIPPLE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] acc_out
);

  logic         take;
  logic [W-1:0] operand;
  logic [W-1:0] next_total;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  acc_operand_mux #(.W(W)) u_mux (
    .restart (load),
    .total   (acc_out),
    .operand (operand)
  );

  acc_adder #(.W(W), .IMPL(IMPL)) u_add (
    .a   (operand),
    .b   (in_data),
    .sum (next_total)
  );

  acc_word_reg #(.W(W)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (take),
    .d   (next_total),
    .q   (acc_out)
  );

  a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
    (in_valid && load) |=> (acc_out == $past(in_data)))
    else $error("R2: load did not capture the input word");

  a_r3_accumulates: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !load) |=> (acc_out == W'($past(acc_out) + $past(in_data))))
    else $error("R3/R6: accumulate result wrong");

endmodule

// File: tb/load_accum_tb_top.sv
module load_accum_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, load, in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic [W-1:0] acc_out;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] expect_q = '0;
  string        tag_q    = "R1";

  always #10 clk = ~clk;  // 50 MHz

  load_accum #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .load(load), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .acc_out(acc_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: at the falling edge, compare with the model, then drive a new beat.
  task automatic step(input logic r, input logic v, input logic l,
                      input logic [W-1:0] d, input string tag);
    @(negedge clk);
    chk(tag_q, acc_out, expect_q);
    chk("R7", {7'd0, in_ready}, 8'd1);
    rst = r; in_valid = v; load = l; in_data = d;
    if (r)      expect_q = '0;
    else if (v) expect_q = l ? d : W'(expect_q + d);
    tag_q = r ? "R1" : (!v ? "R4" : (l ? "R2" : "R3"));
    #4;
    // R5: a fresh input between edges must not reach the output.
    in_data = d ^ 8'h5A;
    #2;
    chk("R5", acc_out, acc_out_prev);
    in_data = d;
  endtask

  logic [W-1:0] acc_out_prev;
  always @(negedge clk) acc_out_prev = acc_out;

  initial begin
    rst = 1'b1; load = 1'b0; in_valid = 1'b0; in_data = '0;
    step(1, 1, 0, 8'd77, "R1");
    step(1, 0, 0, 8'd0,  "R1");
    // Example sequence: x0, x1, x2 with load first, then reload at x3.
    step(0, 1, 1, 8'd5,  "R2");
    step(0, 1, 0, 8'd7,  "R3");
    step(0, 1, 0, 8'd11, "R3");
    step(0, 1, 1, 8'd20, "R2");
    step(0, 1, 0, 8'd3,  "R3");
    step(0, 1, 0, 8'd4,  "R3");
    // Idle beats: load and data ignored (R4).
    step(0, 0, 1, 8'd99, "R4");
    step(0, 0, 0, 8'd42, "R4");
    step(0, 1, 0, 8'd1,  "R3");
    // Wrap: 200 + 100 = 44 (R6).
    step(0, 1, 1, 8'd200, "R6");
    step(0, 1, 0, 8'd100, "R6");
    step(0, 1, 0, 8'd255, "R6");
    // Back-to-back loads.
    step(0, 1, 1, 8'd9,  "R2");
    step(0, 1, 1, 8'd10, "R2");
    // Reset mid-run.
    step(1, 1, 1, 8'd50, "R1");
    step(0, 1, 0, 8'd6,  "R3");
    for (int i = 0; i < 40; i++)
      step(0, (i % 5) != 4, (i % 7) == 0, W'(i * 37 + 13), "R3");
    step(0, 0, 0, 8'd0, "R4");
    @(negedge clk);
    chk(tag_q, acc_out, expect_q);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule